// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI-style transfer engine from the module clock. A 13-bit clock-control word chooses between two ways of dividing. The linear mode divides by 2×(N+1), where N is an 8-bit field. The power-of-two mode divides by 2^(M+1), where M is a 4-bit field. Whichever mode is chosen, the output clock has a 50% duty cycle. The block also gives the transfer engine a toggle enable and separate rising and falling edge strobes. The engine uses these strobes to shift and sample its data in the module clock domain.

The divider runs only while `xfer_active` is high. While it is idle, its counter and its serial clock are held at zero. The control word is taken in the first cycle of a transfer and is then held until that transfer ends. A change written during a transfer therefore only applies to the next one. All ports are plain control signals, and there is no data stream or handshake.

Top module: `sclk_divider`

## Requirements
- R1: During reset and in the first cycle after it, `sclk`, `tgl_en`, `rise_stb` and `fall_stb` are all low.
- R2: While `xfer_active` is low, `tgl_en`, `rise_stb` and `fall_stb` stay low, and `sclk` is low from the next cycle on, whatever `div_cfg` holds.
- R3: When bit 12 of `div_cfg` is 1 (linear mode), each high phase and each low phase of `sclk` lasts N+1 module cycles, where N is `div_cfg[7:0]`.
- R4: When bit 12 of `div_cfg` is 0 (power-of-two mode), each high phase and each low phase lasts 2^M module cycles, where M is `div_cfg[11:8]`. This covers M=15 (32768 cycles).
- R5: Count the first cycle in which `xfer_active` is high as cycle 0. With H as the half-period, `sclk` is first high in cycle H, and `rise_stb` is high in cycle H-1.
- R6: The high phase and the low phase of `sclk` are equal in length, so the duty cycle is 50%.
- R7: `rise_stb` is high only when `sclk` is low and `sclk` is high in the next cycle. `fall_stb` is the mirror case. The two strobes are never high together, and `sclk` changes only after a cycle in which `tgl_en` is high.
- R8: A change to `div_cfg` while a transfer is active does not alter the clock of that transfer. The next transfer uses the new value.
- R9: In linear mode with N=0, or in power-of-two mode with M=0, `sclk` toggles every module cycle.
- R10: The field that the selected mode does not use has no effect: M is ignored in linear mode, and N is ignored in power-of-two mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High for the whole of a transfer |
| div_cfg | input | 13 | [7:0] linear N, [11:8] exponent M, [12] mode (1 linear, 0 power-of-two) |
| sclk | output | 1 | Divided serial clock, idles low |
| tgl_en | output | 1 | One-cycle pulse in the cycle before `sclk` toggles |
| rise_stb | output | 1 | One-cycle pulse in the cycle before `sclk` rises |
| fall_stb | output | 1 | One-cycle pulse in the cycle before `sclk` falls |

## Verification
Some properties hold on every cycle, and the assertions check these continuously. The idle outputs stay quiet, the two strobes never overlap, a rise strobe is followed by a high clock and a fall strobe by a low clock, and the clock holds its level whenever no toggle is enabled. The bench scenarios cover what depends on the control word. They measure the exact phase lengths in both modes, the delay to the first edge, the extreme values N=0, N=255, M=0 and M=15, the fact that the unused field has no effect, and the freezing of the configuration across a write made during a transfer.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  // Width needed to hold the largest half-period of either mode.
  function automatic int half_width(input int lin_w, input int exp_w);
    int lin_bits;
    int pow_bits;
    lin_bits = lin_w + 1;
    pow_bits = (1 << exp_w) - 1 + 1;
    return (lin_bits > pow_bits) ? lin_bits : pow_bits;
  endfunction

endpackage

// File: rtl/sclk_div_cfg_hold.sv
module sclk_div_cfg_hold
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1,
  localparam int HW    = half_width(LIN_W, EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [HW-1:0]    half_len
);

  logic             running_q;
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] eff_cfg;
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_m;
  div_mode_e        mode;

  // Shadow follows the input until the first active edge, then freezes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      shadow_q  <= '0;
    end else begin
      running_q <= xfer_active;
      if (!running_q) shadow_q <= cfg_in;
    end
  end

  // In the first active cycle the live input is used directly.
  assign eff_cfg = running_q ? shadow_q : cfg_in;
  assign lin_n   = eff_cfg[LIN_W-1:0];
  assign exp_m   = eff_cfg[LIN_W +: EXP_W];
  assign mode    = div_mode_e'(eff_cfg[CFG_W-1]);

  always_comb begin
    if (mode == DIV_LINEAR) half_len = HW'(lin_n) + HW'(1);
    else                    half_len = HW'(1) << exp_m;
  end

endmodule

// File: rtl/sclk_div_counter.sv
module sclk_div_counter #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_active,
  input  logic [HW-1:0] half_len,
  output logic          tick
);

  logic [HW-1:0] cnt_q;

  assign tick = xfer_active && (cnt_q == (half_len - HW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!xfer_active) cnt_q <= '0;
    else if (tick)        cnt_q <= '0;
    else                  cnt_q <= cnt_q + HW'(1);
  end

endmodule

// File: rtl/sclk_div_edge.sv
module sclk_div_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_active,
  input  logic tick,
  output logic sclk,
  output logic tgl_en,
  output logic rise_stb,
  output logic fall_stb
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sclk_q <= 1'b0;
    else if (!xfer_active) sclk_q <= 1'b0;
    else if (tick)         sclk_q <= ~sclk_q;
  end

  assign sclk     = sclk_q;
  assign tgl_en   = tick;
  assign rise_stb = tick & ~sclk_q;
  assign fall_stb = tick &  sclk_q;

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1,
  localparam int HW    = half_width(LIN_W, EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             sclk,
  output logic             tgl_en,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [HW-1:0] half_len;
  logic          tick;

  sclk_div_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .cfg_in      (div_cfg),
    .half_len    (half_len)
  );

  sclk_div_counter #(.HW(HW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .half_len    (half_len),
    .tick        (tick)
  );

  sclk_div_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .tick        (tick),
    .sclk        (sclk),
    .tgl_en      (tgl_en),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb)
  );

endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_active,
  input logic sclk,
  input logic tgl_en,
  input logic rise_stb,
  input logic fall_stb
);

  AST_IDLE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> !tgl_en && !rise_stb && !fall_stb); // R2

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !sclk); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R7

  AST_RISE_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !sclk ##1 sclk); // R7

  AST_FALL_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> sclk ##1 !sclk); // R7

  AST_HOLD_WITHOUT_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active && !tgl_en |=> $stable(sclk)); // R7

endmodule

bind sclk_divider sclk_divider_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .sclk        (sclk),
  .tgl_en      (tgl_en),
  .rise_stb    (rise_stb),
  .fall_stb    (fall_stb)
);

// File: tb/sclk_divider_tb.sv
module sclk_divider_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_active = 1'b0;
  logic [12:0] div_cfg = '0;
  logic        sclk, tgl_en, rise_stb, fall_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sclk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .div_cfg(div_cfg),
    .sclk(sclk), .tgl_en(tgl_en), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // Stimulus: control word; expected: half-period in module cycles.
  localparam logic [12:0] VEC_CFG [8] = '{
    13'h1000, 13'h1003, 13'h10FF, 13'h1709,
    13'h0000, 13'h0200, 13'h053C, 13'h0F00 };
  localparam int VEC_HALF [8] = '{
    1, 4, 256, 10,
    1, 4, 32, 32768 };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Run one transfer; optionally rewrite the config at the start of the high phase.
  task automatic run_xfer(input logic [12:0] cfg, input bit mid_chg,
                          input logic [12:0] cfg2,
                          output int first, output int high, output int low,
                          output int rises, output int falls);
    @(negedge clk);
    div_cfg = cfg;
    @(negedge clk);
    xfer_active = 1'b1;
    #1;
    first = 0; rises = 0; falls = 0;
    if (rise_stb) rises++;
    while (!sclk) begin
      @(negedge clk); first++;
      if (rise_stb) rises++;
    end
    if (mid_chg) div_cfg = cfg2;
    high = 0;
    while (sclk) begin
      if (fall_stb) falls++;
      @(negedge clk); high++;
    end
    low = 0;
    while (!sclk) begin
      @(negedge clk); low++;
    end
    xfer_active = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f, h, l, r, fa;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sclk in reset", sclk, 0);
    chk("R1 strobes in reset", tgl_en | rise_stb | fall_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sclk after reset", sclk, 0);

    // Table walk: R3/R4/R5/R6/R9/R10
    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = VEC_CFG[i][12] ? "R3" : "R4";
      run_xfer(VEC_CFG[i], 1'b0, '0, f, h, l, r, fa);
      chk({"R5 first edge ", tg}, f, VEC_HALF[i]);
      chk({tg, " high phase"}, h, VEC_HALF[i]);
      chk({"R6 low phase ", tg}, l, VEC_HALF[i]);
      chk("R7 one rise strobe", r, 1);
      chk("R7 one fall strobe", fa, 1);
      if (VEC_HALF[i] == 1) chk("R9 divide by two", h + l, 2);
      if (i == 3 || i == 6) chk("R10 unused field ignored", h, VEC_HALF[i]);
      chk("R2 sclk low after end", sclk, 0);
    end

    // R2: idle with changing config, no activity
    begin
      int act_seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        div_cfg = 13'(k * 37);
        #1;
        if (sclk | tgl_en | rise_stb | fall_stb) act_seen++;
      end
      chk("R2 idle quiet", act_seen, 0);
    end

    // R8: change during transfer is ignored, next transfer uses it
    run_xfer(13'h1002, 1'b1, 13'h1007, f, h, l, r, fa);
    chk("R8 high unchanged", h, 3);
    chk("R8 low unchanged", l, 3);
    run_xfer(13'h1007, 1'b0, '0, f, h, l, r, fa);
    chk("R8 next transfer new value", h, 8);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule